// File: doc/BRIEF.md
# Power-Partition Gating Register Controller

This block switches seven power partitions on and off and controls their isolation clamps under command of a simple word-addressed register bus. Software powers a partition on or off by writing its index to a toggle register together with a start flag. The write inverts the power state of that partition. A status register reports which partitions are powered. A separate clamp-release register removes isolation from any set of partitions in one write. The clamp-release bits for partitions 3 and 4 are wired crosswise.

Each partition drives a power-enable output and a clamp-enable output. After reset every partition is unpowered and clamped. A partition is re-clamped at the same edge that powers it off. A clamp can only be released while its partition is powered, so an unpowered partition is never unclamped.

Top module: `pwr_part_ctrl`

## Requirements
- R1: After reset all power enables are 0, all clamp enables are 1, and a status read returns 0.
- R2: A write to byte offset 0x30 with bit 8 set and an index 0..6 in bits [7:0] inverts that partition's power enable at the next clock edge. No other partition changes.
- R3: A write to offset 0x30 with bit 8 clear changes no output.
- R4: A write to offset 0x30 with bit 8 set and an index of 7 or more in bits [7:0] changes no output.
- R5: A read of offset 0x38 returns the power enables in bits [6:0] and zeros above them. The data appears on the cycle after the read strobe.
- R6: A write to offset 0x34 clears the clamp enable of every powered partition whose mask bit is set. Mask bits 0, 1, 2, 5 and 6 map straight to partitions 0, 1, 2, 5 and 6.
- R7: In the clamp mask, bit 3 releases partition 4 and bit 4 releases partition 3.
- R8: Powering a partition off sets its clamp enable at the same edge. A release aimed at an unpowered partition is ignored, so a powered-off partition is always clamped.
- R9: Reads of any offset other than 0x38 return 0. Writes to offsets other than 0x30 and 0x34 change no output.
- R10: Clamp-mask bits 7 and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| pwr_en_o | output | 7 | Per-partition power enable |
| clamp_o | output | 7 | Per-partition clamp enable |

## Verification
The power and clamp state bits drive the outputs directly. A wrong toggle decode, a missed swap or a clamp left released therefore shows on pwr_en_o or clamp_o one cycle after the offending write. The bench checks both vectors after every write. The crossed clamp bits are exercised with only partition 3 or only partition 4 powered. This lets a straight-wired mask leave the wrong clamp released. A status read then confirms the register path agrees with the output pins one cycle later.

// File: rtl/pwr_part_pkg.sv
package pwr_part_pkg;
  localparam int NUM_PART  = 7;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = 8;
  localparam int START_BIT = 8;
  localparam int SWAP_A    = 3;
  localparam int SWAP_B    = 4;
  localparam logic [ADDR_W-1:0] OFF_TOGGLE = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h38;
endpackage

// File: rtl/pwr_part_regif.sv
module pwr_part_regif
  import pwr_part_pkg::*;
#(
  parameter int N      = NUM_PART,
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  parameter int IW     = IDX_W,
  parameter int SBIT   = START_BIT,
  parameter int SA     = SWAP_A,
  parameter int SB     = SWAP_B
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  status_i,
  output logic [N-1:0]  tog_sel_o,
  output logic [N-1:0]  rel_sel_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [IW-1:0] N_L = IW'(N);

  logic          hit_tog, hit_clr, tog_go;
  logic [IW-1:0] idx;
  logic [DW-1:0] rdata_q;

  assign hit_tog = wr_i && (addr_i == AW'(OFF_TOGGLE));
  assign hit_clr = wr_i && (addr_i == AW'(OFF_CLR));
  assign idx     = wdata_i[IW-1:0];
  assign tog_go  = hit_tog && wdata_i[SBIT] && (idx < N_L);

  for (genvar i = 0; i < N; i++) begin : g_sel
    localparam int SRC = (i == SA) ? SB : ((i == SB) ? SA : i);
    assign tog_sel_o[i] = tog_go && (idx == IW'(i));
    assign rel_sel_o[i] = hit_clr && wdata_i[SRC];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i && addr_i == AW'(OFF_STAT)) rdata_q <= DW'(status_i);
    else rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  AST_ONE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tog_sel_o)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != AW'(OFF_STAT)) |=> (rdata_o == '0)); // R9
  AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(OFF_STAT)) |=> (rdata_o == DW'($past(status_i)))); // R5
endmodule

// File: rtl/pwr_part_slice.sv
module pwr_part_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  input  logic rel_i,
  output logic pwr_o,
  output logic clamp_o
);
  logic pwr_q, clamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= 1'b0;
      clamp_q <= 1'b1;
    end else begin
      pwr_q <= pwr_q ^ tog_i;
      if (tog_i && pwr_q)      clamp_q <= 1'b1;  // going off
      else if (rel_i && pwr_q) clamp_q <= 1'b0;  // only while powered
    end
  end

  assign pwr_o   = pwr_q;
  assign clamp_o = clamp_q;

  AST_OFF_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_q |-> clamp_q); // R8
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_i |=> (pwr_q != $past(pwr_q))); // R2
  AST_NO_TOGGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tog_i |=> $stable(pwr_q)); // R3
endmodule

// File: rtl/pwr_part_ctrl.sv
module pwr_part_ctrl
  import pwr_part_pkg::*;
#(
  parameter int N  = NUM_PART,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  pwr_en_o,
  output logic [N-1:0]  clamp_o
);
  logic [N-1:0] tog_sel, rel_sel;

  pwr_part_regif #(.N(N), .AW(AW), .DW(DW)) u_regif (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .status_i (pwr_en_o),
    .tog_sel_o(tog_sel),
    .rel_sel_o(rel_sel),
    .rdata_o
  );

  for (genvar i = 0; i < N; i++) begin : g_part
    pwr_part_slice u_slice (
      .clk_i, .rst_ni,
      .tog_i  (tog_sel[i]),
      .rel_i  (rel_sel[i]),
      .pwr_o  (pwr_en_o[i]),
      .clamp_o(clamp_o[i])
    );
  end
endmodule

// File: tb/pwr_part_ctrl_test.sv
`timescale 1ns/1ps
module pwr_part_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  pwr_en_o, clamp_o;
  int total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  pwr_part_ctrl uut (.*);

  // {addr, data, exp_pwr, exp_clamp, req}
  localparam int NV = 15;
  localparam logic [61:0] TBL [NV] = '{
    {8'h30, 32'h0000_0100, 7'h01, 7'h7f, 8'd2},  // R2 part0 on
    {8'h30, 32'h0000_0104, 7'h11, 7'h7f, 8'd2},  // R2 part4 on
    {8'h30, 32'h0000_0003, 7'h11, 7'h7f, 8'd3},  // R3 no start
    {8'h30, 32'h0000_0107, 7'h11, 7'h7f, 8'd4},  // R4 idx 7
    {8'h30, 32'h0000_01ff, 7'h11, 7'h7f, 8'd4},  // R4 idx 255
    {8'h34, 32'h0000_0008, 7'h11, 7'h6f, 8'd7},  // R7 bit3 -> part4
    {8'h34, 32'h0000_0001, 7'h11, 7'h6e, 8'd6},  // R6 direct
    {8'h30, 32'h0000_0103, 7'h19, 7'h6e, 8'd2},  // R2 part3 on
    {8'h34, 32'h0000_0010, 7'h19, 7'h66, 8'd7},  // R7 bit4 -> part3
    {8'h34, 32'h0000_0004, 7'h19, 7'h66, 8'd8},  // R8 off part ignored
    {8'h3c, 32'h0000_01ff, 7'h19, 7'h66, 8'd9},  // R9 unmapped write
    {8'h34, 32'hffff_ff80, 7'h19, 7'h66, 8'd10}, // R10 high mask bits
    {8'h30, 32'h0000_0100, 7'h18, 7'h67, 8'd8},  // R8 off re-clamps
    {8'h30, 32'h0000_0106, 7'h58, 7'h67, 8'd2},  // R2 part6 on
    {8'h34, 32'hffff_ffff, 7'h58, 7'h27, 8'd6}   // R6 release all powered
  };

  task automatic chk(input string req, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pwr", 32'(pwr_en_o), 32'h0);
    chk("R1 clamp", 32'(clamp_o), 32'h7f);
    do_rd(8'h38, rd); chk("R1 status", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_wr(TBL[i][61:54], TBL[i][53:22]);
      chk($sformatf("R%0d pwr row%0d", TBL[i][7:0], i), 32'(pwr_en_o), 32'(TBL[i][21:15]));
      chk($sformatf("R%0d clamp row%0d", TBL[i][7:0], i), 32'(clamp_o), 32'(TBL[i][14:8]));
    end

    do_rd(8'h38, rd); chk("R5 status", rd, 32'h58);
    do_rd(8'h30, rd); chk("R9 read toggle", rd, 32'h0);
    do_rd(8'h34, rd); chk("R9 read clamp", rd, 32'h0);
    do_rd(8'h00, rd); chk("R9 read unmapped", rd, 32'h0);
    // R2 double toggle restores
    do_wr(8'h30, 32'h105); do_wr(8'h30, 32'h105);
    chk("R2 double toggle", 32'(pwr_en_o), 32'h58);
    do_rd(8'h38, rd); chk("R5 status after", rd, 32'h58);
    // R8 power off part4 re-clamps only part4
    do_wr(8'h30, 32'h104);
    chk("R8 pwr", 32'(pwr_en_o), 32'h48);
    chk("R8 clamp", 32'(clamp_o), 32'h37);
    // R1 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 pwr after reset", 32'(pwr_en_o), 32'h0);
    chk("R1 clamp after reset", 32'(clamp_o), 32'h7f);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule